// File: doc/BRIEF.md
# Integer ALU with Overflow Detection

A purely combinational integer arithmetic and logic unit for the execute stage of a simple load/store pipeline. Two operand words, a separate shift-amount field and a 4-bit operation code go in. A result word and an overflow flag come out in the same cycle. Sign or zero extension of immediates is done upstream, so every operand arrives already at full width.

The adds and subtracts come in two forms. The trapping form raises the overflow flag on two's-complement overflow, and the pipeline turns that flag into an exception. The non-trapping form yields the same bits but keeps the flag low. The unit also does the four bitwise operations, signed and unsigned set-less-than, and six shifts. Three shifts take their amount from the shift field and three take it from operand B.

Top module: `int_alu`

## Requirements
- R1: With op 0 (ADD) or op 1 (ADDU), the result is A + B modulo 2^32.
- R2: With op 2 (SUB) or op 3 (SUBU), the result is A - B modulo 2^32.
- R3: With op 0, overflow is 1 exactly when A and B have the same sign bit and the sign bit of the result differs from it.
- R4: With op 2, overflow is 1 exactly when A and B have different sign bits and the sign bit of the result differs from that of A.
- R5: Overflow is 0 for every op code other than 0 and 2, including ADDU and SUBU.
- R6: Op 4 gives A AND B, op 5 gives A OR B, op 6 gives A XOR B, and op 7 gives NOT (A OR B), bit by bit across all 32 bits.
- R7: Op 8 (SLT) gives 1 in bit 0 and zeros above when A is less than B as signed two's-complement numbers, and gives all zeros otherwise. This holds even when A - B would overflow.
- R8: Op 9 (SLTU) gives 1 when A is less than B as unsigned magnitudes, and 0 otherwise.
- R9: Shifts by the shift field work as follows. Op 10 shifts A left and fills with zeros. Op 11 shifts A right and fills with zeros. Op 12 shifts A right and fills with copies of A[31]. A shift field of 0 returns A unchanged.
- R10: Ops 13, 14 and 15 are the left-logical, right-logical and right-arithmetic shifts of A by B[4:0]. B[31:5] and the shift field have no effect on these ops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (0..15, see requirements) |
| a_i | input | 32 | First operand, and the value shifted by shift ops |
| b_i | input | 32 | Second operand; its low 5 bits give the amount for variable shifts |
| shamt_i | input | 5 | Amount for constant shifts |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow on ADD or SUB |

## Verification
The checks are immediate and sampled whenever an input changes, so they assume the inputs settle to known, two-valued levels and never carry X or Z. The bench applies each operand set as a single update at a clock edge and reads the outputs half a period later, so no partial combination is ever presented. Op codes cover the full 4-bit space, so no input value falls outside the defined encoding.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W = 32
) (
  input  logic [3:0]         op_i,
  input  logic [W-1:0]       a_i,
  input  logic [W-1:0]       b_i,
  input  logic [$clog2(W)-1:0] shamt_i,
  output logic [W-1:0]       result_o,
  output logic               ovf_o
);
  localparam int SW = $clog2(W);

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDU = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SUBU = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_OR   = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_NOR  = 4'd7;
  localparam logic [3:0] OP_SLT  = 4'd8;
  localparam logic [3:0] OP_SLTU = 4'd9;
  localparam logic [3:0] OP_SLL  = 4'd10;
  localparam logic [3:0] OP_SRL  = 4'd11;
  localparam logic [3:0] OP_SRA  = 4'd12;
  localparam logic [3:0] OP_SLLV = 4'd13;
  localparam logic [3:0] OP_SRLV = 4'd14;
  localparam logic [3:0] OP_SRAV = 4'd15;

  logic         is_sub;
  logic [W-1:0] b_eff;
  logic [W:0]   sum;
  logic         ovf_raw;
  logic         lt_s, lt_u;
  logic         var_sh;
  logic [SW-1:0] amt;
  logic [W-1:0] shl, shr, sha;

  // add/sub/compare share one adder; B is inverted with carry-in for anything but add
  assign is_sub  = (op_i != OP_ADD) && (op_i != OP_ADDU);
  assign b_eff   = is_sub ? ~b_i : b_i;
  assign sum     = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
  assign ovf_raw = (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);

  assign lt_s = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : sum[W-1];
  assign lt_u = ~sum[W];

  assign var_sh = (op_i == OP_SLLV) || (op_i == OP_SRLV) || (op_i == OP_SRAV);
  assign amt    = var_sh ? b_i[SW-1:0] : shamt_i;
  assign shl    = a_i << amt;
  assign shr    = a_i >> amt;
  assign sha    = W'($signed(a_i) >>> amt);

  assign ovf_o = ((op_i == OP_ADD) || (op_i == OP_SUB)) && ovf_raw;

  always_comb begin
    case (op_i)
      OP_ADD, OP_ADDU,
      OP_SUB, OP_SUBU: result_o = sum[W-1:0];
      OP_AND:          result_o = a_i & b_i;
      OP_OR:           result_o = a_i | b_i;
      OP_XOR:          result_o = a_i ^ b_i;
      OP_NOR:          result_o = ~(a_i | b_i);
      OP_SLT:          result_o = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:         result_o = {{(W-1){1'b0}}, lt_u};
      OP_SLL, OP_SLLV: result_o = shl;
      OP_SRL, OP_SRLV: result_o = shr;
      default:         result_o = sha;
    endcase
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int W = 32
) (
  input logic [3:0]            op_i,
  input logic [W-1:0]          a_i,
  input logic [W-1:0]          b_i,
  input logic [$clog2(W)-1:0]  shamt_i,
  input logic [W-1:0]          result_o,
  input logic                  ovf_o
);
  localparam int SW = $clog2(W);

  always_comb begin
    // R5
    no_overflow_chk: assert (ovf_o == 1'b0 || op_i == 4'd0 || op_i == 4'd2);
    // R3
    if (op_i == 4'd0 && a_i[W-1] == b_i[W-1] && result_o[W-1] != a_i[W-1])
      add_ovf_chk: assert (ovf_o);
    // R4
    if (op_i == 4'd2 && a_i[W-1] == b_i[W-1])
      sub_same_sign_chk: assert (!ovf_o);
    // R7
    if (op_i == 4'd8 || op_i == 4'd9)
      slt_width_chk: assert (result_o[W-1:1] == '0);
    // R8
    if (op_i == 4'd9)
      sltu_order_chk: assert (result_o[0] == (a_i < b_i));
    // R10
    if (op_i == 4'd14)
      srlv_amt_chk: assert (result_o == (a_i >> b_i[SW-1:0]));
  end
endmodule

bind int_alu int_alu_chk #(.W(W)) chk_i (
  .op_i(op_i), .a_i(a_i), .b_i(b_i), .shamt_i(shamt_i),
  .result_o(result_o), .ovf_o(ovf_o)
);

// File: tb/int_alu_test.sv
module int_alu_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 29;
  localparam int VW = 110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic [4:0]  sh;
  logic [31:0] res;
  logic        ovf;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu uut (.op_i(op), .a_i(a), .b_i(b), .shamt_i(sh), .result_o(res), .ovf_o(ovf));

  // {req, op, a, b, shamt, result, ovf}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd1,  4'd0,  32'h00000005, 32'h00000007, 5'd0,  32'h0000000C, 1'b0}, // R1
    {4'd3,  4'd0,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b1}, // R3
    {4'd3,  4'd0,  32'h80000000, 32'h80000000, 5'd0,  32'h00000000, 1'b1}, // R3
    {4'd3,  4'd0,  32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000, 1'b0}, // R3
    {4'd5,  4'd1,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b0}, // R5
    {4'd2,  4'd2,  32'h00000005, 32'h00000007, 5'd0,  32'hFFFFFFFE, 1'b0}, // R2
    {4'd4,  4'd2,  32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b1}, // R4
    {4'd4,  4'd2,  32'h00000000, 32'h80000000, 5'd0,  32'h80000000, 1'b1}, // R4
    {4'd4,  4'd2,  32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0,  32'h80000000, 1'b1}, // R4
    {4'd5,  4'd3,  32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b0}, // R5
    {4'd6,  4'd4,  32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'hF000F000, 1'b0}, // R6
    {4'd6,  4'd5,  32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'hFFF0FFF0, 1'b0}, // R6
    {4'd6,  4'd6,  32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'h0FF00FF0, 1'b0}, // R6
    {4'd6,  4'd7,  32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'h000F000F, 1'b0}, // R6
    {4'd7,  4'd8,  32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000001, 1'b0}, // R7
    {4'd7,  4'd8,  32'h00000001, 32'hFFFFFFFF, 5'd0,  32'h00000000, 1'b0}, // R7
    {4'd7,  4'd8,  32'h80000000, 32'h7FFFFFFF, 5'd0,  32'h00000001, 1'b0}, // R7
    {4'd8,  4'd9,  32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000, 1'b0}, // R8
    {4'd8,  4'd9,  32'h00000001, 32'hFFFFFFFF, 5'd0,  32'h00000001, 1'b0}, // R8
    {4'd8,  4'd9,  32'h00000005, 32'h00000005, 5'd0,  32'h00000000, 1'b0}, // R8
    {4'd9,  4'd10, 32'h00000003, 32'h00000000, 5'd4,  32'h00000030, 1'b0}, // R9
    {4'd9,  4'd11, 32'h80000000, 32'h00000000, 5'd31, 32'h00000001, 1'b0}, // R9
    {4'd9,  4'd12, 32'h80000000, 32'h00000000, 5'd4,  32'hF8000000, 1'b0}, // R9
    {4'd9,  4'd12, 32'h40000000, 32'h00000000, 5'd4,  32'h04000000, 1'b0}, // R9
    {4'd9,  4'd10, 32'h12345678, 32'h00000000, 5'd0,  32'h12345678, 1'b0}, // R9
    {4'd10, 4'd13, 32'h00000001, 32'hFFFFFFE3, 5'd9,  32'h00000008, 1'b0}, // R10
    {4'd10, 4'd14, 32'hF0000000, 32'h00000104, 5'd9,  32'h0F000000, 1'b0}, // R10
    {4'd10, 4'd15, 32'hF0000000, 32'hFFFFFFE8, 5'd1,  32'hFFF00000, 1'b0}, // R10
    {4'd5,  4'd4,  32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0,  32'h7FFFFFFF, 1'b0}  // R5
  };

  task automatic check(input int req, input logic [31:0] er, input logic eo);
    checks++;
    if (res !== er || ovf !== eo) begin
      errors++;
      $display("FAIL R%0d op=%0d a=%h b=%h sh=%0d: got res=%h ovf=%b, expected res=%h ovf=%b",
               req, op, a, b, sh, res, ovf, er, eo);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [4:0] s);
    @(posedge clk);
    op = o; a = x; b = y; sh = s;
    #(CLK_PERIOD/2);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    op = 4'd0; a = '0; b = '0; sh = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    check(1, 32'h0, 1'b0); // R1 reset-time state with zero inputs
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][105:102], VEC[i][101:70], VEC[i][69:38], VEC[i][37:33]);
      check(int'(VEC[i][109:106]), VEC[i][32:1], VEC[i][0]);
    end

    // R5: only ADD/SUB may flag, across all op codes on an overflowing pair
    for (int o = 0; o < 16; o++) begin
      apply(o[3:0], 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0);
      checks++;
      if (ovf !== (o == 2)) begin
        errors++;
        $display("FAIL R5 op=%0d: got ovf=%b, expected ovf=%b", o, ovf, (o == 2));
      end
    end

    apply(4'd3, 32'h0, 32'h1, 5'd0);
    check(2, 32'hFFFFFFFF, 1'b0); // R2 SUBU wrap
    apply(4'd15, 32'h80000000, 32'h0000001F, 5'd0);
    check(10, 32'hFFFFFFFF, 1'b0); // R10 full arithmetic shift
    apply(4'd12, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd31);
    check(9, 32'h00000000, 1'b0); // R9 positive SRA by 31
    apply(4'd8, 32'h7FFFFFFF, 32'h80000000, 5'd0);
    check(7, 32'h00000000, 1'b0); // R7 overflowing compare

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule